// File: doc/BRIEF.md
# SDRAM Command and Bank Decoder

This block is the device-side front end of a synchronous DRAM with four banks. On every rising clock edge on which clock enable is high, it samples chip select, the three active-low command strobes, a two-bit bank select and a 13-bit address bus. It turns these inputs into a decoded command code and the address fields that belong to that command. For each bank it keeps an open or closed flag and the row that was opened. It flags any command that does not fit the current bank state.

Address bit 10 means different things for different commands. On a read or write it arms a delayed close of the addressed bank, which takes effect a fixed burst count after the command. On a precharge it widens the close from one bank to every bank. Column width is a parameter. For the widest setting the column skips bit 10, so bit 11 supplies the top column bit. Downstream logic (array control, data path) uses the registered outputs.

Top module: `sdram_cmd_front`

## Requirements
- R1: In reset every bank is closed, every stored row is 0, `cmd_out` is 0 (no-op), and `illegal`, `ap_out`, `cmd_bank`, `row_out` and `col_out` are 0.
- R2: An accepted command (clock enable high, `cs_n` low) shows in `cmd_out` after the next edge. The strobes {ras_n,cas_n,we_n} map to codes as follows: 111→0 no-op, 011→1 activate, 101→2 read, 100→3 write, 010→4 precharge, 001→5 refresh, 000→6 mode load, 110→7 burst stop.
- R3: With clock enable high and `cs_n` high, `cmd_out` becomes 0 and no bank changes because of the strobes. Pending delayed closes keep counting down.
- R4: An activate to a closed bank opens that bank and stores all 13 address bits as its row, in slice [b*13 +: 13] of `open_rows`. Only an activate opens a bank.
- R5: On an accepted command `col_out` takes addr[COL_W-1:0] when COL_W ≤ 10. When COL_W is 11 it takes {addr[11], addr[9:0]}. `row_out` takes addr and `cmd_bank` takes `ba`. These three outputs hold their values while no command is accepted.
- R6: A read or write to an open bank with addr[10]=1 closes that bank BURST_LEN enabled edges after the command edge. With addr[10]=0 the bank stays open. A later read or write to the same bank restarts the count or cancels it.
- R7: A precharge with addr[10]=1 closes all banks whatever `ba` is. With addr[10]=0 it closes only bank `ba`. Either form cancels any pending delayed close.
- R8: `illegal` is high for one cycle after an activate to an open bank, or after a read or write to a closed bank. Such a command changes no bank state.
- R9: While `cke` is low, no command is accepted and every register holds its value, including the delayed-close counters.
- R10: `ap_out` takes addr[10] on an accepted read, write or precharge, and 0 on any other accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Address bus |
| cmd_out | output | 3 | Decoded command code of the last edge |
| cmd_bank | output | BANK_W | Bank of the last accepted command |
| row_out | output | ADDR_W | Address of the last accepted command as row |
| col_out | output | COL_W | Column field of the last accepted command |
| ap_out | output | 1 | Address bit 10 for read, write and precharge |
| illegal | output | 1 | Command conflicted with bank state |
| bank_open | output | NUM_BANKS | Per-bank open flag |
| open_rows | output | NUM_BANKS*ADDR_W | Stored row per bank |

## Verification
The bound checker checks these properties on every cycle:
- a low clock enable freezes the command output, the bank flags and the rows;
- a deselected edge yields a no-op;
- a bank can only open after an activate that targets it;
- precharge-all empties every bank;
- both kinds of state conflict raise `illegal`.

Other behaviour is shown only by the bench's scenarios, which compare every output against a cycle model after each edge:
- the exact cycle on which a delayed close lands;
- a delayed close being restarted, cancelled or frozen;
- column extraction skipping bit 10;
- the full strobe-to-code table swept over every bank.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

  typedef enum logic [2:0] {
    C_NOP = 3'd0,
    C_ACT = 3'd1,
    C_RD  = 3'd2,
    C_WR  = 3'd3,
    C_PRE = 3'd4,
    C_REF = 3'd5,
    C_MRS = 3'd6,
    C_BST = 3'd7
  } cmd_e;

  // Strobe pattern {ras_n, cas_n, we_n} to command code.
  function automatic cmd_e decode_pins(input logic ras_n, input logic cas_n, input logic we_n);
    case ({ras_n, cas_n, we_n})
      3'b111:  return C_NOP;
      3'b011:  return C_ACT;
      3'b101:  return C_RD;
      3'b100:  return C_WR;
      3'b010:  return C_PRE;
      3'b001:  return C_REF;
      3'b000:  return C_MRS;
      default: return C_BST;
    endcase
  endfunction

  function automatic logic is_burst(input cmd_e c);
    return (c == C_RD) || (c == C_WR);
  endfunction

endpackage

// File: rtl/sdf_decode.sv
module sdf_decode
  import sdf_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ADDR_W = 13,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              accept,
  output cmd_e              cmd,
  output logic [NB-1:0]     act_vec,
  output logic [NB-1:0]     rw_vec,
  output logic [NB-1:0]     pre_vec,
  output logic              pre_all
);

  logic [NB-1:0] sel;

  always_comb begin
    sel     = '0;
    sel[ba] = 1'b1;
  end

  assign accept  = cke & ~cs_n;
  assign cmd     = decode_pins(ras_n, cas_n, we_n);
  assign act_vec = (accept && cmd == C_ACT) ? sel : '0;
  assign rw_vec  = (accept && is_burst(cmd)) ? sel : '0;
  assign pre_all = accept && (cmd == C_PRE) && addr[10];
  assign pre_vec = pre_all ? '1 : ((accept && cmd == C_PRE) ? sel : '0);

endmodule

// File: rtl/sdf_bank.sv
module sdf_bank #(
  parameter int ROW_W     = 13,
  parameter int BURST_LEN = 4,
  localparam int CNT_W    = $clog2(BURST_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             act,
  input  logic             rw,
  input  logic             pre,
  input  logic             ap,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q,
  output logic             err
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BURST_LEN);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  assign err = (act & is_open) | (rw & ~is_open);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row_q   <= '0;
      cnt     <= '0;
    end else if (en) begin
      if (pre) begin
        is_open <= 1'b0;
        cnt     <= '0;
      end else if (act && !is_open) begin
        is_open <= 1'b1;
        row_q   <= row_in;
        cnt     <= '0;
      end else if (rw && is_open) begin
        cnt <= ap ? LOAD : '0;
      end else if (cnt != '0) begin
        if (cnt == ONE) is_open <= 1'b0;
        cnt <= cnt - ONE;
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
  import sdf_pkg::*;
#(
  parameter int COL_W     = 9,
  parameter int BURST_LEN = 4,
  parameter int BANK_W    = 2,
  parameter int ADDR_W    = 13,
  localparam int NUM_BANKS = 1 << BANK_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cke,
  input  logic                        cs_n,
  input  logic                        ras_n,
  input  logic                        cas_n,
  input  logic                        we_n,
  input  logic [BANK_W-1:0]           ba,
  input  logic [ADDR_W-1:0]           addr,
  output logic [2:0]                  cmd_out,
  output logic [BANK_W-1:0]           cmd_bank,
  output logic [ADDR_W-1:0]           row_out,
  output logic [COL_W-1:0]            col_out,
  output logic                        ap_out,
  output logic                        illegal,
  output logic [NUM_BANKS-1:0]        bank_open,
  output logic [NUM_BANKS*ADDR_W-1:0] open_rows
);

  logic                 accept;
  cmd_e                 cmd;
  logic [NUM_BANKS-1:0] act_vec;
  logic [NUM_BANKS-1:0] rw_vec;
  logic [NUM_BANKS-1:0] pre_vec;
  logic                 pre_all;
  logic [NUM_BANKS-1:0] err_vec;
  logic [COL_W-1:0]     col_next;

  sdf_decode #(.BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .accept(accept), .cmd(cmd),
    .act_vec(act_vec), .rw_vec(rw_vec), .pre_vec(pre_vec), .pre_all(pre_all)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    sdf_bank #(.ROW_W(ADDR_W), .BURST_LEN(BURST_LEN)) u_bank (
      .clk(clk), .rst_n(rst_n), .en(cke),
      .act(act_vec[b]), .rw(rw_vec[b]), .pre(pre_vec[b]), .ap(addr[10]),
      .row_in(addr), .is_open(bank_open[b]),
      .row_q(open_rows[b*ADDR_W +: ADDR_W]), .err(err_vec[b])
    );
  end

  // Column field: the widest organisation steps over the auto-precharge bit.
  if (COL_W >= 11) begin : g_col_wide
    assign col_next = {addr[COL_W:11], addr[9:0]};
  end else begin : g_col_narrow
    assign col_next = addr[COL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_out  <= C_NOP;
      cmd_bank <= '0;
      row_out  <= '0;
      col_out  <= '0;
      ap_out   <= 1'b0;
      illegal  <= 1'b0;
    end else if (cke) begin
      illegal <= |err_vec;
      if (accept) begin
        cmd_out  <= cmd;
        cmd_bank <= ba;
        row_out  <= addr;
        col_out  <= col_next;
        ap_out   <= (is_burst(cmd) || cmd == C_PRE) ? addr[10] : 1'b0;
      end else begin
        cmd_out <= C_NOP;
      end
    end
  end

endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
  parameter int NB = 4,
  parameter int AW = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             cs_n,
  input logic [2:0]       cmd_out,
  input logic             illegal,
  input logic [NB-1:0]    bank_open,
  input logic [NB*AW-1:0] open_rows,
  input logic [NB-1:0]    act_vec,
  input logic [NB-1:0]    rw_vec,
  input logic             pre_all
);

  assert_cke_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(bank_open) && $stable(cmd_out) && $stable(open_rows));

  assert_deselect_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && cs_n) |=> cmd_out == 3'd0);

  assert_pre_all_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && pre_all) |=> bank_open == '0);

  assert_act_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && |(act_vec & bank_open)) |=> illegal);

  assert_rw_conflict_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && |(rw_vec & ~bank_open)) |=> illegal);

  for (genvar g = 0; g < NB; g++) begin : g_open
    assert_open_by_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_open[g]) |-> $past(act_vec[g]));
  end

endmodule

bind sdram_cmd_front sdf_checker #(.NB(NUM_BANKS), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .cmd_out(cmd_out),
  .illegal(illegal), .bank_open(bank_open), .open_rows(open_rows),
  .act_vec(act_vec), .rw_vec(rw_vec), .pre_all(pre_all)
);

// File: tb/sdram_cmd_front_tb.sv
`timescale 1ns/1ps
module sdram_cmd_front_tb;

  localparam int BL = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b0, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [2:0]  cmd_out;
  logic [1:0]  cmd_bank;
  logic [12:0] row_out;
  logic [10:0] col_out;
  logic        ap_out, illegal;
  logic [3:0]  bank_open;
  logic [51:0] open_rows;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  // bench model
  logic [3:0]  m_open = '0;
  logic [12:0] m_row [4];
  int          m_cnt [4];
  logic [2:0]  e_cmd = '0;
  logic [1:0]  e_bank = '0;
  logic [12:0] e_row = '0;
  logic [10:0] e_col = '0;
  logic        e_ap = 1'b0, e_ill = 1'b0;

  always #4 clk = ~clk;

  sdram_cmd_front #(.COL_W(11), .BURST_LEN(BL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_out(cmd_out), .cmd_bank(cmd_bank),
    .row_out(row_out), .col_out(col_out), .ap_out(ap_out), .illegal(illegal),
    .bank_open(bank_open), .open_rows(open_rows)
  );

  function automatic logic [2:0] code_of(input logic [2:0] s);
    logic [2:0] t [8] = '{3'd6, 3'd5, 3'd4, 3'd1, 3'd3, 3'd2, 3'd7, 3'd0};
    return t[s];
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [51:0] rows;
    for (int i = 0; i < 4; i++) rows[i*13 +: 13] = m_row[i];
    check({tag, " R2 cmd_out"}, 64'(cmd_out), 64'(e_cmd));
    check({tag, " R6 bank_open"}, 64'(bank_open), 64'(m_open));
    check({tag, " R4 open_rows"}, 64'(open_rows), 64'(rows));
    check({tag, " R8 illegal"}, 64'(illegal), 64'(e_ill));
    check({tag, " R5 col/row/bank"}, {26'd0, col_out, row_out, cmd_bank}, {26'd0, e_col, e_row, e_bank});
    check({tag, " R10 ap_out"}, 64'(ap_out), 64'(e_ap));
  endtask

  task automatic step(input string tag, input logic k, input logic cs, input logic [2:0] s,
                      input logic [1:0] b, input logic [12:0] a);
    logic [3:0] touched;
    logic [2:0] c;
    cke = k; cs_n = cs; {ras_n, cas_n, we_n} = s; ba = b; addr = a;
    if (k) begin
      touched = '0;
      e_ill = 1'b0;
      if (!cs) begin
        c = code_of(s);
        e_cmd = c; e_bank = b; e_row = a; e_col = {a[11], a[9:0]};
        e_ap = (c == 3'd2 || c == 3'd3 || c == 3'd4) ? a[10] : 1'b0;
        if (c == 3'd1) begin
          if (m_open[b]) e_ill = 1'b1;
          else begin m_open[b] = 1'b1; m_row[b] = a; m_cnt[b] = 0; touched[b] = 1'b1; end
        end else if (c == 3'd2 || c == 3'd3) begin
          if (!m_open[b]) e_ill = 1'b1;
          else begin m_cnt[b] = a[10] ? BL : 0; touched[b] = 1'b1; end
        end else if (c == 3'd4) begin
          for (int i = 0; i < 4; i++)
            if (a[10] || i == int'(b)) begin m_open[i] = 1'b0; m_cnt[i] = 0; touched[i] = 1'b1; end
        end
      end else begin
        e_cmd = 3'd0;
      end
      for (int i = 0; i < 4; i++)
        if (!touched[i] && m_cnt[i] != 0) begin
          if (m_cnt[i] == 1) m_open[i] = 1'b0;
          m_cnt[i]--;
        end
    end
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
  endtask

  task automatic nop(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1'b1, 1'b0, 3'b111, 2'd0, 13'd0);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 4; i++) begin m_row[i] = '0; m_cnt[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    compare_all("R1 reset");
    rst_n = 1'b1;
    cke = 1'b1;

    // R2 sweep of all strobe patterns over all banks
    for (int s = 0; s < 8; s++)
      for (int b = 0; b < 4; b++)
        step("R2 sweep", 1'b1, 1'b0, 3'(s), 2'(b), 13'(s * 977 + b * 311));

    // R7 precharge all with bank select pointing elsewhere
    for (int b = 0; b < 4; b++) step("R4 open", 1'b1, 1'b0, 3'b011, 2'(b), 13'h1000 + 13'(b * 13'h111));
    step("R7 pre all", 1'b1, 1'b0, 3'b010, 2'd2, 13'h0400);
    check("R7 all closed", 64'(bank_open), 64'd0);
    for (int b = 0; b < 4; b++) step("R4 reopen", 1'b1, 1'b0, 3'b011, 2'(b), 13'h0A5A ^ 13'(b));
    step("R7 pre one", 1'b1, 1'b0, 3'b010, 2'd1, 13'h0000);
    check("R7 only bank1 closed", 64'(bank_open), 64'hD);

    // R8 conflicts
    step("R8 act open", 1'b1, 1'b0, 3'b011, 2'd0, 13'h1FFF);
    step("R8 rd closed", 1'b1, 1'b0, 3'b101, 2'd1, 13'h0003);

    // R6 delayed close and its timing
    step("R6 rd ap", 1'b1, 1'b0, 3'b101, 2'd2, 13'h0C55);
    nop("R6 wait", BL - 1);
    check("R6 still open", 64'(bank_open[2]), 64'd1);
    nop("R6 land", 1);
    check("R6 closed", 64'(bank_open[2]), 64'd0);
    step("R6 wr no ap", 1'b1, 1'b0, 3'b100, 2'd3, 13'h0123);
    nop("R6 stays", BL + 2);
    step("R6 rearm", 1'b1, 1'b0, 3'b100, 2'd0, 13'h0400);
    nop("R6 mid", 2);
    step("R6 cancel", 1'b1, 1'b0, 3'b101, 2'd0, 13'h0000);
    nop("R6 cancelled", BL + 1);

    // R3 deselect with activate strobes; pending close keeps counting
    step("R3 arm", 1'b1, 1'b0, 3'b100, 2'd3, 13'h0400);
    for (int i = 0; i < BL + 1; i++) step("R3 deselect", 1'b1, 1'b1, 3'b011, 2'd1, 13'h0777);
    check("R3 bank1 stays closed", 64'(bank_open[1]), 64'd0);

    // R9 clock enable low freezes a pending close
    step("R9 open", 1'b1, 1'b0, 3'b011, 2'd1, 13'h0ABC);
    step("R9 arm", 1'b1, 1'b0, 3'b101, 2'd1, 13'h0401);
    for (int i = 0; i < 6; i++) step("R9 frozen", 1'b0, 1'b0, 3'b010, 2'd1, 13'h0400);
    check("R9 held open", 64'(bank_open[1]), 64'd1);
    nop("R9 resume", BL);

    // mixed pseudo-random sweep
    lf = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("mix", lf[15:12] != 4'd0, lf[11:9] == 3'd7, lf[2:0], lf[4:3], {lf[8:5], lf[12:4]});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule